// File: doc/BRIEF.md
# Audio Receiver Bit-Clock Prescaler

This block turns the system clock into the serial bit clock of an audio receiver. The clock passes through three divider stages in series. The first is a fixed divide-by-eight stage that a range bit can bypass. The second is a programmable divider whose 8-bit modulus value N divides by N+1. The last is a toggle stage that gives a 50% duty cycle. The total ratio is therefore 2 × (8 or 1) × (N+1). The fastest output is the system clock divided by 4 and the slowest is the system clock divided by 4096.

The divided clock leaves the block as a level output for a pin. It is also issued as a one-cycle shift strobe that marks each rising edge, so the receive shift logic can stay on the system clock. The modulus and range inputs are sampled only when the bit clock toggles, so a reprogramming never produces a runt half period. Setting the range bit together with modulus zero is forbidden: the block flags it and runs at the fastest legal rate instead.

Top module: `rx_bitclk_prescaler`

## Requirements
- R1: While reset is held, and after release until the divider has started, `bit_clk`, `shift_strobe` and `cfg_illegal` are all 0.
- R2: With `cfg_range_bypass`=0 and modulus N, every high phase and every low phase of `bit_clk` lasts 8×(N+1) system clock cycles.
- R3: With `cfg_range_bypass`=1 and modulus N≥1, every phase of `bit_clk` lasts N+1 cycles. N=1 gives the fastest clock: 2 cycles high and 2 cycles low.
- R4: Under any fixed legal configuration, the high phase and the low phase of `bit_clk` have equal length.
- R5: `shift_strobe` is 1 for exactly the one cycle in which `bit_clk` has just risen, and is 0 in every other cycle.
- R6: `cfg_illegal` is 1 one cycle after the inputs show `cfg_range_bypass`=1 together with `cfg_modulus`=0. It is 0 one cycle after any other input pattern.
- R7: The forbidden pattern is never applied. While it is present, the divider runs as if the modulus were 1 with the bypass set, which gives phases of 2 cycles.
- R8: A change of the configuration inputs does not shorten or stretch the phase in progress. That phase ends with its old length, and the next phase has the new length.
- R9: With `cfg_range_bypass`=0 and modulus 255, each phase lasts 2048 cycles, so the full period is 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_modulus | input | 8 | Programmable divider value N; the ratio is N+1 |
| cfg_range_bypass | input | 1 | 1 bypasses the fixed divide-by-eight stage |
| bit_clk | output | 1 | Generated bit clock for the pin |
| shift_strobe | output | 1 | One-cycle pulse at each rising edge of `bit_clk` |
| cfg_illegal | output | 1 | Registered flag for the forbidden configuration |

## Verification
The divider is driven with directed values that hit its extremes: modulus 0 with the stage active, the fastest legal pair, modulus 255 with the stage active, and the forbidden pair. The extremes catch errors of one in the counter limit and a swapped sense of the range bit. Seeded random pairs of modulus and range bit then check that the phase length follows (N+1) scaled by 8 or 1, and that high and low phases match, over many ratios. A change in the middle of a phase checks that the old length finishes before the new one applies. A monitor running all the time compares the strobe with the rising edges it sees on the clock pin.

// File: rtl/rxbc_pkg.sv
package rxbc_pkg;
  localparam int RXBC_MOD_W     = 8;
  localparam int RXBC_FIXED_DIV = 8;

  typedef enum logic {
    PRE_FIXED  = 1'b0,
    PRE_BYPASS = 1'b1
  } rxbc_range_e;
endpackage

// File: rtl/rxbc_reset_sync.sv
module rxbc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rxbc_cfg_guard.sv
module rxbc_cfg_guard #(
  parameter int MOD_W = rxbc_pkg::RXBC_MOD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MOD_W-1:0] cfg_mod,
  input  logic             cfg_bypass,
  output logic [MOD_W-1:0] act_mod,
  output logic             act_bypass,
  output logic             armed,
  output logic             illegal
);
  import rxbc_pkg::*;

  logic             forbidden;
  logic [MOD_W-1:0] mod_safe;
  logic [MOD_W-1:0] act_mod_d;
  logic             act_bypass_d;
  logic             illegal_d;

  always_comb begin
    forbidden    = (cfg_bypass == PRE_BYPASS) && (cfg_mod == '0);
    mod_safe     = forbidden ? MOD_W'(1) : cfg_mod;
    act_mod_d    = load ? mod_safe : act_mod;
    act_bypass_d = load ? cfg_bypass : act_bypass;
    illegal_d    = forbidden;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mod    <= '0;
      act_bypass <= 1'b0;
      armed      <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      act_mod    <= act_mod_d;
      act_bypass <= act_bypass_d;
      armed      <= 1'b1;
      illegal    <= illegal_d;
    end
  end

  // R7: the forbidden pair never becomes the active setting
  a_r7_no_forbidden_active: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && act_bypass) |-> (act_mod != '0));

  // R6: the flag follows the input pattern one cycle later
  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass && (cfg_mod == '0)) |=> illegal);

  // R8: the active setting moves only on a load
  a_r8_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !load) |=> ($stable(act_mod) && $stable(act_bypass)));
endmodule

// File: rtl/rxbc_fixed_prescale.sv
module rxbc_fixed_prescale #(
  parameter int FIXED_DIV = rxbc_pkg::RXBC_FIXED_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bypass,
  output logic tick
);
  localparam int CNT_W = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FIXED_DIV - 1);

  generate
    if (FIXED_DIV > 1) begin : g_div
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;

      always_comb begin
        tick = en && (bypass || (cnt_q == LAST));
        if (!en || bypass || tick) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      // R2: a tick of the active stage leaves the counter at zero
      a_r2_wraps_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bypass && tick) |=> (cnt_q == '0));
    end else begin : g_none
      always_comb begin
        tick = en;
      end
    end
  endgenerate

  // R3: with the bypass set, every enabled cycle ticks
  a_r3_bypass_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bypass) |-> tick);
endmodule

// File: rtl/rxbc_modulus_div.sv
module rxbc_modulus_div #(
  parameter int MOD_W = rxbc_pkg::RXBC_MOD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [MOD_W-1:0] limit,
  output logic             tc,
  output logic [MOD_W-1:0] cnt
);
  logic [MOD_W-1:0] cnt_d;

  always_comb begin
    tc = tick && (cnt == limit);
    if (clear || tc) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt + MOD_W'(1);
    end else begin
      cnt_d = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

  // R2: the counter never passes the active limit
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (cnt <= limit));
endmodule

// File: rtl/rxbc_toggle_out.sv
module rxbc_toggle_out (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tc,
  output logic bit_clk,
  output logic strobe
);
  logic bit_clk_d;
  logic strobe_d;

  always_comb begin
    if (clear) begin
      bit_clk_d = 1'b0;
      strobe_d  = 1'b0;
    end else begin
      bit_clk_d = tc ? ~bit_clk : bit_clk;
      strobe_d  = tc && !bit_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_clk <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      bit_clk <= bit_clk_d;
      strobe  <= strobe_d;
    end
  end

  // R1: a cleared stage drives the clock low
  a_r1_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !bit_clk);

  // R5: the strobe never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/rx_bitclk_prescaler.sv
module rx_bitclk_prescaler #(
  parameter int MOD_W     = rxbc_pkg::RXBC_MOD_W,
  parameter int FIXED_DIV = rxbc_pkg::RXBC_FIXED_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MOD_W-1:0] cfg_modulus,
  input  logic             cfg_range_bypass,
  output logic             bit_clk,
  output logic             shift_strobe,
  output logic             cfg_illegal
);
  logic             rst_sync_n;
  logic             load;
  logic             armed;
  logic [MOD_W-1:0] act_mod;
  logic             act_bypass;
  logic             pre_tick;
  logic             mod_tc;
  logic [MOD_W-1:0] mod_cnt;

  rxbc_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    load = mod_tc || !armed;
  end

  rxbc_cfg_guard #(.MOD_W(MOD_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (load),
    .cfg_mod    (cfg_modulus),
    .cfg_bypass (cfg_range_bypass),
    .act_mod    (act_mod),
    .act_bypass (act_bypass),
    .armed      (armed),
    .illegal    (cfg_illegal)
  );

  rxbc_fixed_prescale #(.FIXED_DIV(FIXED_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (armed),
    .bypass (act_bypass),
    .tick   (pre_tick)
  );

  rxbc_modulus_div #(.MOD_W(MOD_W)) u_mod (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (!armed),
    .tick  (pre_tick),
    .limit (act_mod),
    .tc    (mod_tc),
    .cnt   (mod_cnt)
  );

  rxbc_toggle_out u_out (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear   (!armed),
    .tc      (mod_tc),
    .bit_clk (bit_clk),
    .strobe  (shift_strobe)
  );

  // R5: every rising edge of the clock carries a strobe
  a_r5_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(bit_clk) |-> shift_strobe);

  // R8: the clock moves only as the modulus counter restarts
  a_r8_edge_at_restart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(bit_clk) |-> (mod_cnt == '0));
endmodule

// File: tb/rx_bitclk_prescaler_bench.sv
module rx_bitclk_prescaler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 10000;

  logic       clk;
  logic       rst_n;
  logic [7:0] cfg_modulus;
  logic       cfg_range_bypass;
  logic       bit_clk;
  logic       shift_strobe;
  logic       cfg_illegal;

  int checks;
  int errors;
  int strobe_bad;
  int cycles;
  logic prev_clk;
  logic mon_en;
  logic done;

  rx_bitclk_prescaler u_rx_bitclk_prescaler (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_modulus      (cfg_modulus),
    .cfg_range_bypass (cfg_range_bypass),
    .bit_clk          (bit_clk),
    .shift_strobe     (shift_strobe),
    .cfg_illegal      (cfg_illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_half(input logic [7:0] m, input logic byp);
    if (byp && m == 8'd0) return 2;
    return (byp ? 1 : 8) * (int'(m) + 1);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R5 monitor: strobe must match rising edges seen on the pin
  always @(negedge clk) begin
    if (mon_en && (shift_strobe !== (bit_clk && !prev_clk))) strobe_bad++;
    prev_clk = bit_clk;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_edge(input int start, output int len);
    logic lvl;
    lvl = bit_clk;
    len = start;
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      @(negedge clk);
      len++;
      if (bit_clk !== lvl) return;
    end
    len = -1;
  endtask

  task automatic set_cfg(input logic [7:0] m, input logic byp);
    cfg_modulus      = m;
    cfg_range_bypass = byp;
  endtask

  task automatic run_cfg(input logic [7:0] m, input logic byp, input int halves, input string tag);
    int len;
    int hi;
    int lo;
    int e;
    hi = -1;
    lo = -1;
    e = exp_half(m, byp);
    set_cfg(m, byp);
    wait_edge(0, len);
    for (int k = 0; k < halves; k++) begin
      wait_edge(0, len);
      check(len == e, tag, len, e);
      if (bit_clk) lo = len; else hi = len;
    end
    check(hi == lo, "R4 duty", hi, lo);
  endtask

  initial begin
    int len;
    checks = 0; errors = 0; strobe_bad = 0; cycles = 0;
    prev_clk = 1'b0; mon_en = 1'b0; done = 1'b0;
    void'($urandom(32'd5120));
    rst_n = 1'b0;
    set_cfg(8'd0, 1'b0);
    repeat (4) @(negedge clk);
    check(bit_clk == 1'b0 && shift_strobe == 1'b0 && cfg_illegal == 1'b0,
          "R1 reset outputs", int'({bit_clk, shift_strobe, cfg_illegal}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_clk == 1'b0 && shift_strobe == 1'b0,
          "R1 after release", int'({bit_clk, shift_strobe}), 0);
    mon_en = 1'b1;

    run_cfg(8'd0, 1'b0, 4, "R2 modulus 0 fixed stage");
    run_cfg(8'd3, 1'b0, 4, "R2 modulus 3 fixed stage");
    run_cfg(8'd1, 1'b1, 6, "R3 fastest");
    run_cfg(8'd6, 1'b1, 4, "R3 modulus 6 bypass");
    run_cfg(8'd255, 1'b0, 2, "R9 slowest");

    // R6 / R7: forbidden pair
    set_cfg(8'd0, 1'b1);
    @(negedge clk);
    check(cfg_illegal == 1'b1, "R6 flag set", int'(cfg_illegal), 1);
    run_cfg(8'd0, 1'b1, 4, "R7 forbidden runs at 2");
    set_cfg(8'd2, 1'b1);
    @(negedge clk);
    check(cfg_illegal == 1'b0, "R6 flag clear", int'(cfg_illegal), 0);

    // R8: change in the middle of a phase
    run_cfg(8'd3, 1'b0, 2, "R8 setup");
    @(negedge clk);
    set_cfg(8'd1, 1'b1);
    wait_edge(1, len);
    check(len == 32, "R8 old phase kept", len, 32);
    wait_edge(0, len);
    check(len == 2, "R8 new phase", len, 2);
    set_cfg(8'd9, 1'b0);
    wait_edge(0, len);
    check(len == 2, "R8 old phase kept fast", len, 2);
    wait_edge(0, len);
    check(len == 80, "R8 new phase slow", len, 80);

    // random configurations
    for (int n = 0; n < 16; n++) begin
      logic [7:0] m;
      logic b;
      m = 8'($urandom % 24);
      b = 1'($urandom % 2);
      run_cfg(m, b, 2, b ? "R3 random" : "R2 random");
    end

    check(strobe_bad == 0, "R5 strobe on rising edges", strobe_bad, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule